// File: doc/BRIEF.md
# Dual-Modulus RF Divider Controller

This block holds the digital control for the feedback divider of a frequency synthesiser. A prescaler stage, modelled here as a counter of input clocks, divides by either 8 or 9. Two down-counters steer it. The swallow count A sets how many prescaler cycles use the divide-by-9 modulus. The main count M sets how many prescaler cycles make up one output period. Over one period the block counts 8M + A input clocks, then emits a one-clock pulse for the phase detector.

The division word arrives on a parallel bus through a strobe-controlled buffer. While the strobe is high, the buffer follows the bus and the counters stay cleared. The cycle in which the strobe is first seen low freezes the buffer and loads the counters, and counting starts. At the end of each period both counters reload from the frozen buffer, so the ratio repeats until the next strobe. A word whose ratio is below the legal minimum, or whose A exceeds M, sends the block into a fault state. That state raises a sticky error and stops output until the strobe rises again.

The control sits in a five-state machine:

- IDLE: the state after reset, before any strobe.
- HOLD: the strobe is high.
- NINE: the swallow phase, divide-by-9.
- EIGHT: the main phase, divide-by-8.
- FAULT: an illegal word was loaded.

The transitions are:

- IDLE to HOLD, and any state to HOLD, when the strobe is high.
- HOLD to NINE when a legal word with A nonzero is loaded.
- HOLD to EIGHT when a legal word with A zero is loaded.
- HOLD to FAULT when an illegal word is loaded.
- NINE to EIGHT at the prescaler wrap that ends the A-th swallow cycle.
- NINE or EIGHT back to its reload phase at the terminal wrap. The reload phase is NINE when A is nonzero and EIGHT when A is zero.

Top module: `dmd_divider`

## Requirements
- R1: After synchronous reset, and for as long as no strobe arrives, `div_pulse`, `mod_sel` and `ratio_err` stay low.
- R2: While `strobe` is high, `div_pulse` and `mod_sel` are low. The word loaded is the bus value in the last cycle in which the strobe was sampled high.
- R3: The word places A in bits [2:0] and M in bits [13:3]. After a legal load, the first `div_pulse` appears in the (8M+A)-th clock cycle after the loading edge.
- R4: Within each period, `mod_sel` (1 = divide by 9) is high for exactly the first 9A clocks and low for the remaining 8(M−A).
- R5: `div_pulse` is one clock wide and occurs exactly once per period.
- R6: Changes on `prog_word` while `strobe` is low leave the running ratio unchanged.
- R7: A loaded word with 8M+A < 56 or A > M drives `ratio_err` high from the cycle after loading. The error stays high, with no `div_pulse` and `mod_sel` low, until the next strobe.
- R8: `ratio_err` is low in the cycle after the strobe is sampled high.
- R9: An all-ones word, the value that unconnected bus inputs read, gives the maximum ratio of 16383.
- R10: The counters reload automatically, so consecutive periods have equal length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock (one RF cycle per clock) |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | Buffer transparent and counters held while high; load on first low cycle |
| prog_word | input | 14 | Division word: A in [2:0], M in [13:3] |
| div_pulse | output | 1 | One-clock pulse at the end of each divided period |
| mod_sel | output | 1 | Prescaler modulus select, 1 = divide by 9 |
| ratio_err | output | 1 | Sticky illegal-word flag |

## Verification
The bench builds the block with its default parameters: a 3-bit swallow field, an 11-bit main field, an 8/9 prescaler and a minimum ratio of 56. These defaults bring the smallest legal ratios (56 and 63, where A equals M) within reach, along with the largest ratio of 16383 from an all-ones word. Because the limit of 56 with a 3-bit A implies M ≥ 7, every legal word has M ≥ A. The two illegal words the bench uses, 48 and 55, sit just below the limit, and the second of them also has A > M.

// File: rtl/dmd_pkg.sv
package dmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HOLD  = 3'd1,
        ST_NINE  = 3'd2,
        ST_EIGHT = 3'd3,
        ST_FAULT = 3'd4
    } dmd_state_e;

endpackage

// File: rtl/dmd_strobe_buf.sv
module dmd_strobe_buf #(
    parameter int A_W       = 3,
    parameter int M_W       = 11,
    parameter int PRESCALE  = 8,
    parameter int RATIO_MIN = 56
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               strobe_i,
    input  logic [A_W+M_W-1:0] word_i,
    output logic [A_W-1:0]     a_o,
    output logic [M_W-1:0]     m_o,
    output logic               load_o,
    output logic               bad_o
);
    localparam int WORD_W = A_W + M_W;
    localparam int RW     = M_W + $clog2(PRESCALE) + 2;

    logic [WORD_W-1:0] word_q;
    logic              strobe_q;
    logic [RW-1:0]     ratio;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q   <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= strobe_i;
            if (strobe_i) begin
                word_q <= word_i;
            end
        end
    end

    assign a_o    = word_q[A_W-1:0];
    assign m_o    = word_q[WORD_W-1:A_W];
    assign load_o = strobe_q & ~strobe_i;

    always_comb begin
        ratio = RW'(PRESCALE) * RW'(m_o) + RW'(a_o);
        bad_o = (ratio < RW'(RATIO_MIN)) || (RW'(a_o) > RW'(m_o));
    end

    AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
        !strobe_i |=> $stable(word_q)); // R6

endmodule

// File: rtl/dmd_prescaler.sv
module dmd_prescaler #(
    parameter int PRESCALE = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic run_i,
    input  logic nine_i,
    output logic wrap_o
);
    localparam int PC_W = $clog2(PRESCALE + 1);

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] limit;

    always_comb begin
        limit  = nine_i ? PC_W'(PRESCALE) : PC_W'(PRESCALE - 1);
        wrap_o = run_i && (pc_q == limit);
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            pc_q <= '0;
        end else if (run_i) begin
            pc_q <= wrap_o ? '0 : pc_q + PC_W'(1);
        end
    end

    AST_PC_BOUND: assert property (@(posedge clk) disable iff (rst)
        run_i && !nine_i |-> pc_q < PC_W'(PRESCALE)); // R4

endmodule

// File: rtl/dmd_swallow_fsm.sv
module dmd_swallow_fsm
    import dmd_pkg::*;
#(
    parameter int A_W = 3,
    parameter int M_W = 11
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           strobe_i,
    input  logic           load_i,
    input  logic           bad_i,
    input  logic [A_W-1:0] a_i,
    input  logic [M_W-1:0] m_i,
    input  logic           wrap_i,
    output logic           run_o,
    output logic           nine_o,
    output logic           div_pulse_o,
    output logic           mod_sel_o,
    output logic           err_o
);
    dmd_state_e     state_q, state_d, first_phase;
    logic [A_W-1:0] a_left_q;
    logic [M_W-1:0] m_left_q;
    logic           terminal;

    always_comb begin
        first_phase = (a_i != '0) ? ST_NINE : ST_EIGHT;
        terminal    = wrap_i && (m_left_q == M_W'(1));
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (strobe_i) state_d = ST_HOLD;
            ST_HOLD:  if (load_i) state_d = bad_i ? ST_FAULT : first_phase;
            ST_NINE: begin
                if (terminal)
                    state_d = first_phase;
                else if (wrap_i && (a_left_q == A_W'(1)))
                    state_d = ST_EIGHT;
            end
            ST_EIGHT: if (terminal) state_d = first_phase;
            ST_FAULT: state_d = ST_FAULT;
            default:  state_d = ST_IDLE;
        endcase
        if (strobe_i) state_d = ST_HOLD;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // swallow and main counters
    always_ff @(posedge clk) begin
        if (rst || strobe_i) begin
            a_left_q <= '0;
            m_left_q <= '0;
        end else if (load_i || terminal) begin
            a_left_q <= a_i;
            m_left_q <= m_i;
        end else if (wrap_i) begin
            m_left_q <= m_left_q - M_W'(1);
            if (state_q == ST_NINE) a_left_q <= a_left_q - A_W'(1);
        end
    end

    // outputs
    always_comb begin
        run_o       = (state_q == ST_NINE) || (state_q == ST_EIGHT);
        nine_o      = (state_q == ST_NINE);
        mod_sel_o   = nine_o;
        div_pulse_o = run_o && terminal;
        err_o       = (state_q == ST_FAULT);
    end

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
        strobe_i |=> !div_pulse_o && !mod_sel_o); // R2
    AST_PULSE_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
        div_pulse_o |=> !div_pulse_o); // R5
    AST_FAULT_SILENT: assert property (@(posedge clk) disable iff (rst)
        err_o |-> !div_pulse_o && !mod_sel_o); // R7
    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        strobe_i |=> !err_o); // R8
    AST_MOD_FALL_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        $fell(mod_sel_o) |-> $past(wrap_i) || $past(strobe_i)); // R4

endmodule

// File: rtl/dmd_divider.sv
module dmd_divider #(
    parameter int A_W       = 3,
    parameter int M_W       = 11,
    parameter int PRESCALE  = 8,
    parameter int RATIO_MIN = 56
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               strobe,
    input  logic [A_W+M_W-1:0] prog_word,
    output logic               div_pulse,
    output logic               mod_sel,
    output logic               ratio_err
);
    logic [A_W-1:0] a_val;
    logic [M_W-1:0] m_val;
    logic           load, bad, wrap, run, nine;

    dmd_strobe_buf #(
        .A_W(A_W), .M_W(M_W), .PRESCALE(PRESCALE), .RATIO_MIN(RATIO_MIN)
    ) u_buf (
        .clk(clk), .rst(rst), .strobe_i(strobe), .word_i(prog_word),
        .a_o(a_val), .m_o(m_val), .load_o(load), .bad_o(bad)
    );

    dmd_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk(clk), .rst(rst), .clear_i(load | strobe),
        .run_i(run), .nine_i(nine), .wrap_o(wrap)
    );

    dmd_swallow_fsm #(.A_W(A_W), .M_W(M_W)) u_fsm (
        .clk(clk), .rst(rst), .strobe_i(strobe), .load_i(load), .bad_i(bad),
        .a_i(a_val), .m_i(m_val), .wrap_i(wrap),
        .run_o(run), .nine_o(nine), .div_pulse_o(div_pulse),
        .mod_sel_o(mod_sel), .err_o(ratio_err)
    );

endmodule

// File: tb/tb_dmd_divider.sv
`timescale 1ns/1ps
module tb_dmd_divider;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strobe = 1'b0;
    logic [13:0] prog_word = '0;
    logic        div_pulse, mod_sel, ratio_err;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dmd_divider dut (
        .clk(clk), .rst(rst), .strobe(strobe), .prog_word(prog_word),
        .div_pulse(div_pulse), .mod_sel(mod_sel), .ratio_err(ratio_err)
    );

    localparam int NV = 7;
    localparam int VA [NV] = '{0, 7, 3, 5, 1, 0, 7};
    localparam int VM [NV] = '{7, 7, 10, 100, 255, 6, 6};
    localparam int VE [NV] = '{0, 0, 0, 0, 0, 1, 1};

    function automatic logic [13:0] mk(input int a, input int m);
        return {m[10:0], a[2:0]};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // strobe high one cycle with word w, then low; returns just before the loading edge
    task automatic load_word(input logic [13:0] w);
        @(negedge clk);
        strobe = 1'b1;
        prog_word = w;
        @(negedge clk);
        check("R2 hold pulse", int'(div_pulse), 0);
        check("R2 hold mod_sel", int'(mod_sel), 0);
        strobe = 1'b0;
        prog_word = ~w;
    endtask

    task automatic run_period(input int a, input int m, input string tag);
        int n = 8 * m + a;
        int first = 0, second = 0, npulse = 0, nmod = 0, lastmod = 0, errs = 0;
        for (int k = 1; k <= 2 * n + 1; k++) begin
            @(negedge clk);
            if (div_pulse) begin
                npulse++;
                if (first == 0) first = k;
                else if (second == 0) second = k;
            end
            if (k <= n && mod_sel) begin
                nmod++;
                lastmod = k;
            end
            if (ratio_err) errs++;
            if (k == 5) prog_word = 14'h2aaa; // R6: bus moves while strobe low
        end
        check({tag, " R3 first pulse"}, first, n);
        check({tag, " R6 R10 second pulse"}, second, 2 * n);
        check({tag, " R5 pulse count"}, npulse, 2);
        check({tag, " R4 div9 cycles"}, nmod, 9 * a);
        check({tag, " R4 last div9 cycle"}, lastmod, 9 * a);
        check({tag, " R7 no error"}, errs, 0);
    endtask

    task automatic run_fault(input string tag);
        int errs = 0, pulses = 0, mods = 0;
        for (int k = 1; k <= 200; k++) begin
            @(negedge clk);
            if (ratio_err) errs++;
            if (div_pulse) pulses++;
            if (mod_sel) mods++;
        end
        check({tag, " R7 err sticky"}, errs, 200);
        check({tag, " R7 no pulse"}, pulses, 0);
        check({tag, " R7 mod_sel low"}, mods, 0);
        @(negedge clk);
        strobe = 1'b1;
        prog_word = '0;
        @(negedge clk);
        check({tag, " R8 err cleared"}, int'(ratio_err), 0);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 reset pulse", int'(div_pulse), 0);
        check("R1 reset mod_sel", int'(mod_sel), 0);
        check("R1 reset err", int'(ratio_err), 0);
        rst = 1'b0;
        begin
            int act = 0;
            for (int k = 0; k < 100; k++) begin
                @(negedge clk);
                act += int'(div_pulse) + int'(mod_sel) + int'(ratio_err);
            end
            check("R1 idle quiet", act, 0);
        end

        // table walk
        for (int i = 0; i < NV; i++) begin
            load_word(mk(VA[i], VM[i]));
            if (VE[i] != 0) run_fault($sformatf("vec%0d", i));
            else run_period(VA[i], VM[i], $sformatf("vec%0d", i));
        end

        // R2: last value seen while strobe high is the one loaded
        @(negedge clk);
        strobe = 1'b1;
        prog_word = mk(2, 9);
        @(negedge clk);
        prog_word = mk(4, 20);
        @(negedge clk);
        check("R2 high pulse", int'(div_pulse), 0);
        check("R2 high mod_sel", int'(mod_sel), 0);
        strobe = 1'b0;
        prog_word = mk(1, 7);
        run_period(4, 20, "R2 last-word");

        // R1: reset in mid-run
        load_word(mk(3, 10));
        repeat (40) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 midrun pulse", int'(div_pulse), 0);
        check("R1 midrun mod_sel", int'(mod_sel), 0);
        rst = 1'b0;
        begin
            int act = 0;
            for (int k = 0; k < 300; k++) begin
                @(negedge clk);
                act += int'(div_pulse) + int'(mod_sel) + int'(ratio_err);
            end
            check("R1 after reset quiet", act, 0);
        end

        // R9: all inputs open
        load_word(14'h3fff);
        run_period(7, 2047, "R9 all-ones");

        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

endmodule